// File: doc/BRIEF.md
# Burst-gated modulator clock for delta-sigma converters

This block takes a free-running reference clock (nominally about 8.192 MHz) and produces a gated modulator clock for a group of delta-sigma converters. For each sample it passes exactly two reference cycles per oversampling step, so a burst is 2×OSR cycles long. It then holds the clock low. A sinc filter that is frozen only at a conversion boundary never averages across a pause, so it always resumes cleanly.

After a burst the block waits for the converters' active-low data-ready line to fall. It then opens a read window, during which the clock stays low and the frame can be read over SPI. The next burst starts in one of two ways. In manual mode a start strobe begins it. In automatic mode it begins after a programmable idle time, which trims the effective sample rate. The first few conversions after a reset or a timeout come from a settling third-order filter, so the block marks them invalid. If data-ready never falls, the block stops with a timeout flag.

Top module: `conv_clk_gate`

## Requirements
- R1: While reset is asserted, `gclk_o`, `busy_o`, `idle_o`, `sample_valid_o` and `timeout_o` are all low.
- R2: Each burst passes exactly 2×OSR rising edges on `gclk_o`. OSR is `OSR_LO` when `osr_sel_i` is 0 and `OSR_HI` when it is 1.
- R3: `gclk_o` stays low outside a burst: in the read window, while waiting for a start, and after a timeout.
- R4: `osr_sel_i` and `idle_len_i` are captured in the cycle a burst starts. Changing them during the burst does not alter that burst's length or the idle time that follows it.
- R5: After the last pulse of a burst, a falling edge on `drdy_n_i` ends the conversion. `busy_o` then drops and `idle_o` rises in the same cycle, opening the read window.
- R6: With `auto_i` = 1, the read window lasts `idle_len`+1 reference cycles, and the next burst then starts without a strobe. A strobe on `start_i` has no effect in this mode while the window is open.
- R7: With `auto_i` = 0, a one-cycle `start_i` while idle or stopped begins a burst. A `start_i` seen while `busy_o` is high is ignored, including in the cycle that data-ready ends the burst.
- R8: Counting from reset or from a timeout, the first `SETTLE` conversions close with `sample_valid_o` low. Every later conversion holds `sample_valid_o` high for its whole read window, and the flag is never high outside one.
- R9: If `drdy_n_i` has not fallen within `MARGIN`+1 cycles after the last pulse of a burst, `timeout_o` rises, `busy_o` drops and the clock stays stopped. The next `start_i` clears `timeout_o` and begins a burst.
- R10: `busy_o` and `idle_o` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Free-running reference clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| osr_sel_i | input | 1 | Oversampling select: 0 gives OSR_LO, 1 gives OSR_HI |
| auto_i | input | 1 | 1 selects periodic restart, 0 selects strobe-paced restart |
| start_i | input | 1 | Start strobe for a burst |
| idle_len_i | input | IDLE_W | Read-window length minus one, in automatic mode |
| drdy_n_i | input | 1 | Converter data-ready, active low |
| gclk_o | output | 1 | Gated modulator clock, low while stopped |
| busy_o | output | 1 | Burst in progress or awaiting data-ready |
| idle_o | output | 1 | Read window open |
| sample_valid_o | output | 1 | The conversion just finished is past filter settling |
| timeout_o | output | 1 | Data-ready missed after a burst |

## Verification
Two events can fall in the same cycle: a start strobe and the end of a burst on data-ready. The bench holds `start_i` high from the last gated pulse until the read window is seen to open. That places the strobe exactly in the cycle where data-ready ends the burst. It then checks that the block stays idle with no further pulses. The same coincidence is provoked in automatic mode, where the captured oversampling and idle settings are scrambled within a cycle of the burst start. The bench checks that the burst length and the window length still follow the captured values.

// File: rtl/conv_clk_gate.sv
module conv_clk_gate #(
  parameter int OSR_LO = 128,
  parameter int OSR_HI = 256,
  parameter int IDLE_W = 12,
  parameter int MARGIN = 8,
  parameter int SETTLE = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              osr_sel_i,
  input  logic              auto_i,
  input  logic              start_i,
  input  logic [IDLE_W-1:0] idle_len_i,
  input  logic              drdy_n_i,
  output logic              gclk_o,
  output logic              busy_o,
  output logic              idle_o,
  output logic              sample_valid_o,
  output logic              timeout_o
);
  localparam int BURST_LO = 2 * OSR_LO;
  localparam int BURST_HI = 2 * OSR_HI;
  localparam int CNT_W = $clog2(BURST_HI + 1);
  localparam int MW = $clog2(MARGIN + 1);
  localparam int SW = $clog2(SETTLE + 1);

  typedef enum logic [1:0] {S_OFF, S_RUN, S_IDLE, S_FLT} st_t;

  st_t               st_q;
  logic [CNT_W-1:0]  cnt_q, burst_q;
  logic [IDLE_W-1:0] icnt_q;
  logic [MW-1:0]     mcnt_q;
  logic [SW-1:0]     sc_q;
  logic              drdy_q, seen_q, valid_q, en_q;

  wire fall   = drdy_q & ~drdy_n_i;
  wire at_end = (st_q == S_RUN) && (cnt_q == burst_q);
  wire done   = at_end && (fall || seen_q);
  wire expire = at_end && !done && (mcnt_q == MW'(MARGIN));
  wire wait_s = (st_q == S_OFF) || (st_q == S_FLT) || (st_q == S_IDLE && !auto_i);
  wire go     = (wait_s && start_i) || (st_q == S_IDLE && auto_i && icnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= S_OFF;
      cnt_q   <= '0;
      burst_q <= CNT_W'(BURST_LO);
      icnt_q  <= '0;
      mcnt_q  <= '0;
      sc_q    <= '0;
      drdy_q  <= 1'b1;
      seen_q  <= 1'b0;
      valid_q <= 1'b0;
    end else begin
      drdy_q <= drdy_n_i;
      if (go) begin
        st_q    <= S_RUN;
        cnt_q   <= '0;
        burst_q <= osr_sel_i ? CNT_W'(BURST_HI) : CNT_W'(BURST_LO);
        icnt_q  <= idle_len_i;
        mcnt_q  <= '0;
        seen_q  <= 1'b0;
        valid_q <= 1'b0;
      end else begin
        case (st_q)
          S_RUN: begin
            if (en_q) cnt_q <= cnt_q + 1'b1;
            if (fall) seen_q <= 1'b1;
            if (done) begin
              st_q    <= S_IDLE;
              valid_q <= (sc_q == SW'(SETTLE));
              if (sc_q != SW'(SETTLE)) sc_q <= sc_q + 1'b1;
            end else if (expire) begin
              st_q    <= S_FLT;
              sc_q    <= '0;
              valid_q <= 1'b0;
            end else if (at_end) begin
              mcnt_q <= mcnt_q + 1'b1;
            end
          end
          S_IDLE: if (icnt_q != '0) icnt_q <= icnt_q - 1'b1;
          default: ;
        endcase
      end
    end
  end

  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) en_q <= 1'b0;
    else         en_q <= (st_q == S_RUN) && (cnt_q != burst_q);
  end

  assign gclk_o         = clk_i & en_q;
  assign busy_o         = (st_q == S_RUN);
  assign idle_o         = (st_q == S_IDLE);
  assign sample_valid_o = valid_q & idle_o;
  assign timeout_o      = (st_q == S_FLT);
endmodule

// File: rtl/conv_clk_gate_chk.sv
module conv_clk_gate_chk #(
  parameter int OSR_HI = 256
) (
  input logic clk_i,
  input logic rst_ni,
  input logic en,
  input logic busy,
  input logic idle,
  input logic valid,
  input logic tmo
);
  localparam int BURST_HI = 2 * OSR_HI;
  int pc;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pc <= 0;
    else         pc <= busy ? pc + int'(en) : 0;
  end

  assert_burst_bound_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pc <= BURST_HI);
  assert_gclk_quiet_idle_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idle |-> !en);
  assert_idle_after_burst_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(idle) |-> $past(busy));
  assert_valid_in_window_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid |-> idle);
  assert_timeout_stopped_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tmo |-> (!busy && !en));
  assert_busy_idle_excl_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(busy && idle));
endmodule

bind conv_clk_gate conv_clk_gate_chk #(.OSR_HI(OSR_HI)) chk_i (
  .clk_i(clk_i), .rst_ni(rst_ni), .en(en_q), .busy(busy_o), .idle(idle_o),
  .valid(sample_valid_o), .tmo(timeout_o)
);

// File: tb/conv_clk_gate_tb_top.sv
module conv_clk_gate_tb_top;
  localparam int OSR_LO = 4, OSR_HI = 8, IDLE_W = 4, MARGIN = 3, SETTLE = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic osr_sel = 1'b0, auto_m = 1'b0, start = 1'b0, drdy_n = 1'b1;
  logic [IDLE_W-1:0] idle_len = '0;
  logic gclk, busy, idle, valid, tmo;

  int checks = 0, errors = 0, nconv = 0;
  int pulses = 0, mbase = 0, mburst = 2 * OSR_LO;
  bit drdy_en = 1'b1;

  always #4 clk = ~clk;

  conv_clk_gate #(.OSR_LO(OSR_LO), .OSR_HI(OSR_HI), .IDLE_W(IDLE_W),
                  .MARGIN(MARGIN), .SETTLE(SETTLE)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .osr_sel_i(osr_sel), .auto_i(auto_m),
    .start_i(start), .idle_len_i(idle_len), .drdy_n_i(drdy_n),
    .gclk_o(gclk), .busy_o(busy), .idle_o(idle), .sample_valid_o(valid),
    .timeout_o(tmo)
  );

  // converter model: data-ready falls after the expected number of pulses
  always @(posedge clk) if (!busy) begin
    mbase  <= pulses;
    mburst <= osr_sel ? 2 * OSR_HI : 2 * OSR_LO;
  end
  always @(posedge gclk) begin
    pulses = pulses + 1;
    drdy_n <= (drdy_en && (pulses - mbase) == mburst) ? 1'b0 : 1'b1;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic strobe();
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
  endtask

  task automatic wait_end();
    for (int n = 0; n < 2000 && !idle && !tmo; n++) @(negedge clk);
  endtask

  task automatic manual_burst(input bit osr);
    int base;
    osr_sel = osr;
    base = pulses;
    strobe();
    wait_end();
    nconv++;
    chk(pulses - base == (osr ? 2*OSR_HI : 2*OSR_LO), "R2 burst length",
        pulses - base, osr ? 2*OSR_HI : 2*OSR_LO);
    chk(idle && !busy, "R5 read window opens", idle, 1);
    chk(valid == (nconv > SETTLE), "R8 settle flag", valid, nconv > SETTLE);
  endtask

  initial begin
    int base, n;
    repeat (3) @(negedge clk);
    chk(!gclk && !busy && !idle && !valid && !tmo, "R1 reset outputs",
        {gclk, busy, idle, valid, tmo}, 0);
    @(negedge clk) rst_n = 1'b1;
    repeat (2) @(negedge clk);

    manual_burst(1'b0);
    base = pulses;
    repeat (12) @(negedge clk);
    chk(pulses == base && idle, "R3 clock quiet in window", pulses - base, 0);

    // R7: strobe mid-burst is ignored
    osr_sel = 1'b0;
    base = pulses;
    strobe();
    repeat (3) @(negedge clk);
    start = 1'b1;
    @(negedge clk) start = 1'b0;
    wait_end();
    nconv++;
    chk(pulses - base == 2*OSR_LO, "R7 busy strobe ignored", pulses - base, 2*OSR_LO);
    chk(valid == (nconv > SETTLE), "R8 settle flag", valid, nconv > SETTLE);

    // R7: strobe coinciding with data-ready end of burst
    base = pulses;
    strobe();
    while (pulses - base < 2*OSR_LO) @(negedge clk);
    start = 1'b1;
    while (!idle) @(negedge clk);
    start = 1'b0;
    nconv++;
    repeat (10) @(negedge clk);
    chk(idle && !busy && pulses - base == 2*OSR_LO, "R7 coincident strobe ignored",
        pulses - base, 2*OSR_LO);

    // R2/R4: OSR change mid-burst has no effect
    base = pulses;
    osr_sel = 1'b1;
    strobe();
    osr_sel = 1'b0;
    wait_end();
    nconv++;
    chk(pulses - base == 2*OSR_HI, "R4 osr captured at start", pulses - base, 2*OSR_HI);
    manual_burst(1'b1);
    manual_burst(1'b0);
    manual_burst(1'b1);

    // R6/R4: automatic pacing sweep
    auto_m = 1'b1;
    for (int o = 0; o < 2; o++) begin
      for (int l = 0; l < (1 << IDLE_W); l++) begin
        while (!idle) @(negedge clk);
        idle_len = IDLE_W'(l);
        osr_sel = o[0];
        while (!busy) @(negedge clk);
        base = pulses;
        idle_len = ~IDLE_W'(l);
        osr_sel = ~o[0];
        wait_end();
        chk(pulses - base == (o ? 2*OSR_HI : 2*OSR_LO), "R2 auto burst length",
            pulses - base, o ? 2*OSR_HI : 2*OSR_LO);
        chk(valid, "R8 valid after settling", valid, 1);
        if (l == 5) begin
          start = 1'b1;
        end
        n = 0;
        while (idle && n < 100) begin
          @(negedge clk);
          start = 1'b0;
          n++;
        end
        chk(n == l + 1, "R6 idle window length", n, l + 1);
      end
    end
    auto_m = 1'b0;
    while (!idle) @(negedge clk);

    // R9: missing data-ready
    drdy_en = 1'b0;
    osr_sel = 1'b0;
    base = pulses;
    strobe();
    for (int k = 0; k < 200 && !tmo; k++) @(negedge clk);
    chk(tmo && !busy && !idle, "R9 timeout raised", tmo, 1);
    chk(pulses - base == 2*OSR_LO, "R9 burst before timeout", pulses - base, 2*OSR_LO);
    base = pulses;
    repeat (10) @(negedge clk);
    chk(pulses == base && tmo, "R3 clock quiet after timeout", pulses - base, 0);
    drdy_en = 1'b1;
    nconv = 0;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    chk(!tmo && busy, "R9 start clears timeout", tmo, 0);
    wait_end();
    nconv++;
    chk(idle && !valid, "R8 invalid after restart", valid, 0);
    for (int k = 0; k < SETTLE; k++) manual_burst(1'b0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 150000);
    checks++;
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule